// File: doc/BRIEF.md
# Debug Link Frame Receiver

This block sits behind a byte-wide serial receiver on a debug link. It turns the incoming byte stream into complete host request frames. A frame is built from four parts, in this order:

- an opening byte that names the command;
- a count byte;
- that many payload bytes;
- a closing byte that makes the 8-bit additive total of the whole frame come to zero.

While the receiver waits for a frame it discards every byte whose top bit is clear. This lets the link find its place again after noise or a lost byte.

Payload bytes go into a local buffer. When the closing byte arrives, the receiver checks the running total. A good frame is then offered to a command engine: the command byte, the count and random read access to the buffer stay on the outputs until the engine acknowledges. A frame with a bad total is thrown away with no sign at the outputs. A frame is also thrown away when its count is larger than the buffer, or when the host goes quiet in the middle of it.

The host is the only master and has at most one request in flight. Any bytes that arrive while a frame is being held are therefore ignored.

Top module: `dlr_frame_rx`

## Requirements
- R1: While hunting for a frame, a byte with bit 7 clear is discarded. A byte with bit 7 set (value 0x80 or above) is taken as the command byte and starts a frame.
- R2: The byte after the command byte is the payload count N (0 to 255). Exactly N payload bytes follow, then the closing byte. When N is 0, the closing byte comes straight after the count.
- R3: Counts up to the parameter DEPTH (at least 19, at most 255) are accepted. A count above DEPTH drops the frame, and the receiver goes back to hunting.
- R4: A frame is good only when the 8-bit sum of every byte, closing byte included, is zero. A bad frame raises neither frmValid nor frmPulse.
- R5: frmPulse is high for exactly one cycle per good frame. That cycle is the first cycle of frmValid, directly after the clock edge that takes in the closing byte.
- R6: frmValid, frmFunc and frmLen stay constant until a cycle with frmAck high. frmValid is low from the following cycle onwards.
- R7: Bytes that arrive while frmValid is high are ignored. They change neither the held command byte, the count nor the buffer, and they start no new frame.
- R8: In the middle of a frame, if TIMEOUT consecutive cycles pass without a byte, the frame is abandoned and the receiver goes back to hunting. Shorter gaps are harmless.
- R9: rdData shows, without a clock delay, the payload byte at index rdAddr. Index 0 is the first payload byte received.
- R10: After reset, frmValid and frmPulse are low and the receiver is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | rxData holds a new byte this cycle |
| frmValid | output | 1 | A good frame is being held |
| frmPulse | output | 1 | One-cycle marker of a new good frame |
| frmFunc | output | 8 | Command byte of the held frame |
| frmLen | output | 8 | Payload count of the held frame |
| rdAddr | input | $clog2(DEPTH) | Payload read index |
| rdData | output | 8 | Payload byte at rdAddr |
| frmAck | input | 1 | Engine releases the held frame |

## Verification
The bench builds the receiver with DEPTH set to 20 and TIMEOUT set to 16. With DEPTH at 20, a count of 19, a count exactly at capacity and a count one past capacity can all be sent in short runs. With TIMEOUT at 16, a stall well under the limit and one well over it both fit in a few dozen cycles, so the abandon path and the tolerated gap are both driven.

// File: rtl/dlr_pkg.sv
`timescale 1ns/1ps
package dlr_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_LEN, ST_DATA, ST_SUM, ST_HOLD
  } dlr_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capFunc;
    logic capLen;
    logic capData;
  } dlr_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lenTooBig;
    logic lenZero;
    logic lastData;
    logic sumGood;
  } dlr_status_t;
endpackage

// File: rtl/dlr_datapath.sv
`timescale 1ns/1ps
module dlr_datapath
  import dlr_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [7:0]                 rxData,
  input  dlr_strobe_t                strb,
  output dlr_status_t                stat,
  output logic [7:0]                 funcReg,
  output logic [7:0]                 lenReg,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic [7:0]                 rdData
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [7:0]        sumReg;
  logic [7:0]        cnt;
  logic [7:0]        bufMem [DEPTH];
  logic [ADDR_W-1:0] wrIdx;

  assign wrIdx = cnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcReg <= '0;
      lenReg  <= '0;
      sumReg  <= '0;
      cnt     <= '0;
    end else begin
      if (strb.capFunc) begin
        funcReg <= rxData;
        sumReg  <= rxData;
      end
      if (strb.capLen) begin
        lenReg <= rxData;
        sumReg <= sumReg + rxData;
        cnt    <= '0;
      end
      if (strb.capData) begin
        sumReg <= sumReg + rxData;
        cnt    <= cnt + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capData) bufMem[wrIdx] <= rxData;
  end

  always_comb begin
    stat.lenTooBig = rxData > 8'(DEPTH);
    stat.lenZero   = rxData == 8'd0;
    stat.lastData  = cnt == (lenReg - 8'd1);
    stat.sumGood   = (sumReg + rxData) == 8'd0;
  end

  assign rdData = (32'(rdAddr) < DEPTH) ? bufMem[rdAddr] : 8'd0;
endmodule

// File: rtl/dlr_ctrl.sv
`timescale 1ns/1ps
module dlr_ctrl
  import dlr_pkg::*;
#(
  parameter int TIMEOUT = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        frmAck,
  input  dlr_status_t stat,
  output dlr_strobe_t strb,
  output logic        frmValid,
  output logic        frmPulse
);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  dlr_state_t      state, nxt;
  logic [TO_W-1:0] idleCnt;
  logic            midFrame;
  logic            timedOut;

  assign midFrame = (state == ST_LEN) || (state == ST_DATA) || (state == ST_SUM);
  assign timedOut = midFrame && !rxValid && (idleCnt == TO_W'(TIMEOUT - 1));

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_HUNT: if (rxValid && rxData[7]) begin
        strb.capFunc = 1'b1;
        nxt = ST_LEN;
      end
      ST_LEN: begin
        if (timedOut) nxt = ST_HUNT;
        else if (rxValid) begin
          strb.capLen = 1'b1;
          if (stat.lenTooBig)    nxt = ST_HUNT;
          else if (stat.lenZero) nxt = ST_SUM;
          else                   nxt = ST_DATA;
        end
      end
      ST_DATA: begin
        if (timedOut) nxt = ST_HUNT;
        else if (rxValid) begin
          strb.capData = 1'b1;
          if (stat.lastData) nxt = ST_SUM;
        end
      end
      ST_SUM: begin
        if (timedOut) nxt = ST_HUNT;
        else if (rxValid) nxt = stat.sumGood ? ST_HOLD : ST_HUNT;
      end
      ST_HOLD: if (frmAck) nxt = ST_HUNT;
      default: nxt = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      frmPulse <= 1'b0;
      idleCnt  <= '0;
    end else begin
      state    <= nxt;
      frmPulse <= (state == ST_SUM) && rxValid && !timedOut && stat.sumGood;
      if (!midFrame || rxValid) idleCnt <= '0;
      else                      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign frmValid = (state == ST_HOLD);
endmodule

// File: rtl/dlr_frame_rx.sv
`timescale 1ns/1ps
module dlr_frame_rx
  import dlr_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int TIMEOUT = 1024
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               rxData,
  input  logic                     rxValid,
  output logic                     frmValid,
  output logic                     frmPulse,
  output logic [7:0]               frmFunc,
  output logic [7:0]               frmLen,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [7:0]               rdData,
  input  logic                     frmAck
);
  dlr_strobe_t strb;
  dlr_status_t stat;

  dlr_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .frmAck(frmAck), .stat(stat), .strb(strb),
    .frmValid(frmValid), .frmPulse(frmPulse)
  );

  dlr_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .strb(strb), .stat(stat),
    .funcReg(frmFunc), .lenReg(frmLen), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/dlr_frame_rx_chk.sv
`timescale 1ns/1ps
module dlr_frame_rx_chk #(
  parameter int DEPTH = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       frmValid,
  input logic       frmPulse,
  input logic       frmAck,
  input logic [7:0] frmFunc,
  input logic [7:0] frmLen
);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    frmPulse |=> !frmPulse);

  p_pulse_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmValid) |-> frmPulse);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmAck) |=> (frmValid && $stable(frmFunc) && $stable(frmLen)));

  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmAck) |=> !frmValid);

  p_len_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmLen <= 8'(DEPTH)));

  p_func_top_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> frmFunc[7]);
endmodule

bind dlr_frame_rx dlr_frame_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmPulse(frmPulse),
  .frmAck(frmAck), .frmFunc(frmFunc), .frmLen(frmLen)
);

// File: tb/sim_dlr_frame_rx.sv
`timescale 1ns/1ps
module sim_dlr_frame_rx;
  localparam int DEPTH   = 20;
  localparam int TIMEOUT = 16;
  localparam int AW      = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    rxData = '0;
  logic          rxValid = 1'b0;
  logic          frmValid, frmPulse;
  logic [7:0]    frmFunc, frmLen, rdData;
  logic [AW-1:0] rdAddr = '0;
  logic          frmAck = 1'b0;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;

  always #4 clk = ~clk;

  dlr_frame_rx #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) u0 (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid),
    .frmValid(frmValid), .frmPulse(frmPulse), .frmFunc(frmFunc),
    .frmLen(frmLen), .rdAddr(rdAddr), .rdData(rdData), .frmAck(frmAck)
  );

  always @(posedge clk) if (rstN && frmPulse) pulseCnt++;

  // {func, len, seed, 6'b0, expectAccept, corrupt}
  localparam logic [31:0] VEC [7] = '{
    {8'hFE, 8'd4,  8'h10, 8'b0000_0010},
    {8'h80, 8'd0,  8'h00, 8'b0000_0010},
    {8'hFD, 8'd19, 8'h05, 8'b0000_0010},
    {8'hFF, 8'd20, 8'h01, 8'b0000_0010},
    {8'hF9, 8'd21, 8'h02, 8'b0000_0000},
    {8'hFC, 8'd3,  8'h07, 8'b0000_0001},
    {8'h9A, 8'd1,  8'h20, 8'b0000_0010}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxData = b; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return seed + 8'(3 * i);
  endfunction

  function automatic logic [7:0] closer(input logic [7:0] f, input logic [7:0] l,
                                        input logic [7:0] seed);
    logic [7:0] s = f + l;
    for (int i = 0; i < int'(l); i++) s += pay(seed, i);
    return 8'(0) - s;
  endfunction

  task automatic sendFrame(input logic [7:0] f, input logic [7:0] l,
                           input logic [7:0] seed, input bit corrupt);
    sendByte(f);
    sendByte(l);
    for (int i = 0; i < int'(l); i++) sendByte(pay(seed, i));
    sendByte(closer(f, l, seed) + (corrupt ? 8'd1 : 8'd0));
  endtask

  task automatic checkPayload(input logic [7:0] l, input logic [7:0] seed, input string tag);
    int bad = 0;
    for (int i = 0; i < int'(l); i++) begin
      rdAddr = AW'(i);
      #1;
      if (rdData !== pay(seed, i)) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic ackFrame();
    @(negedge clk); frmAck = 1'b1;
    @(negedge clk); frmAck = 1'b0;
    check(frmValid == 1'b0, "R6 valid clears after ack", frmValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    idle(3);
    check(frmValid == 1'b0 && frmPulse == 1'b0, "R10 reset outputs", {frmValid, frmPulse}, 0);
    rstN = 1'b1;
    idle(2);
    check(frmValid == 1'b0, "R10 idle after reset", frmValid, 0);

    // table walk: R2 R3 R4 R9
    for (int v = 0; v < 7; v++) begin
      logic [7:0] f, l, sd;
      bit acc, cor;
      f = VEC[v][31:24]; l = VEC[v][23:16]; sd = VEC[v][15:8];
      acc = VEC[v][1]; cor = VEC[v][0];
      p0 = pulseCnt;
      sendFrame(f, l, sd, cor);
      if (acc) begin
        check(frmValid && frmPulse, "R5 valid and pulse after closing byte",
              {frmValid, frmPulse}, 2'b11);
        check(frmFunc == f, "R2 command byte", frmFunc, f);
        check(frmLen == l, "R2 R3 payload count", frmLen, l);
        checkPayload(l, sd, "R9 payload readback");
        idle(1);
        check(frmPulse == 1'b0 && pulseCnt == p0 + 1, "R5 single pulse",
              pulseCnt - p0, 1);
        ackFrame();
      end else begin
        idle(3 * TIMEOUT);
        check(frmValid == 1'b0 && pulseCnt == p0,
              cor ? "R4 bad sum dropped" : "R3 over capacity dropped",
              pulseCnt - p0, 0);
      end
    end

    // R1: leading noise below 0x80 is skipped
    sendByte(8'h00); sendByte(8'h7F); sendByte(8'h12);
    sendFrame(8'hC3, 8'd2, 8'h11, 1'b0);
    check(frmValid && frmFunc == 8'hC3, "R1 resync after noise", frmFunc, 8'hC3);
    ackFrame();

    // R6 R7: hold across a long wait and an intruding frame
    p0 = pulseCnt;
    sendFrame(8'hFE, 8'd4, 8'h10, 1'b0);
    idle(10);
    check(frmValid == 1'b1, "R6 held without ack", frmValid, 1);
    sendFrame(8'hFD, 8'd5, 8'h30, 1'b0);
    check(frmFunc == 8'hFE && frmLen == 8'd4, "R7 held fields untouched",
          frmFunc, 8'hFE);
    checkPayload(8'd4, 8'h10, "R7 buffer untouched");
    check(pulseCnt == p0 + 1, "R7 no new frame while held", pulseCnt - p0, 1);
    ackFrame();
    idle(3 * TIMEOUT);
    check(frmValid == 1'b0, "R7 nothing pending after release", frmValid, 0);

    // R8: short stall tolerated
    sendByte(8'hA5); sendByte(8'd2); sendByte(pay(8'h04, 0));
    idle(TIMEOUT / 2);
    sendByte(pay(8'h04, 1)); sendByte(closer(8'hA5, 8'd2, 8'h04));
    check(frmValid && frmFunc == 8'hA5, "R8 short gap kept", frmValid, 1);
    ackFrame();

    // R8: long stall abandons the frame
    p0 = pulseCnt;
    sendByte(8'hA6); sendByte(8'd3); sendByte(pay(8'h04, 0)); sendByte(pay(8'h04, 1));
    idle(2 * TIMEOUT);
    sendByte(pay(8'h04, 2)); sendByte(closer(8'hA6, 8'd3, 8'h04));
    idle(3 * TIMEOUT);
    check(frmValid == 1'b0 && pulseCnt == p0, "R8 long gap dropped", pulseCnt - p0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule